// File: doc/BRIEF.md
# Two-Channel Attention Request and Settle Status

This block tracks, for each of two DAC output channels, a service request toward the bus controller and whether the channel's analog output is still moving. A request on a channel is raised in two ways. One is a rising edge on an asynchronous external request pin, after the pin is synchronized. The other is a settle timer that runs out a fixed number of clocks after the last command that changed the channel's value. Each request passes through its own enable latch before it reaches the bus-facing attention output.

Bus commands arrive as single-cycle strobes with an operation code and a 2-bit channel select. Commands can test a request behind or ahead of the enable gate, test whether a channel has settled, clear requests, and switch the enable latches on and off. The test result is returned on `q_out` in the same cycle as the strobe. Each value change also starts a retriggerable one-shot that holds a per-channel busy flag while the output is in transition. An initialize input clears all requests and enables and cancels any pending settle timers.

Operation codes for `cmd_op`: 0 gated test, 1 raw/settled test, 2 clear request, 3 disable, 4 enable, 5 clear-all. For clear, disable and enable, a select of 0 acts on channel A only, 1 on channel B only, and 2 or 3 on both.

Top module: `dac_attn_status`

## Requirements
- R1: After reset, or the cycle after `sys_init` is high, both requests and both enables are clear and `attn_out` is 0. A settle timer that is pending when `sys_init` arrives never raises a request.
- R2: A rising edge on `ext_req_in[i]` sets request i on the third rising clock edge after the pin goes high. A pin held high does not set the request again after it is cleared.
- R3: A one-cycle `val_chg[i]` pulse seen at clock edge k sets request i at edge k+SETTLE_CYC and not before. A new pulse restarts the count.
- R4: `busy_out[i]` is high for exactly BUSY_CYC cycles after the last `val_chg[i]` pulse, and a new pulse restarts that window. Op 1 with select 2 (channel A) or 3 (channel B) returns q = 1 exactly when that channel is not busy.
- R5: Op 0 returns q = request AND enable for channel A when select is 0, for channel B when select is 1, and the OR of both gated requests when select is 2 or 3.
- R6: Op 1 with select 0 or 1 returns that channel's request regardless of its enable latch.
- R7: Op 2 clears the selected requests. If a set event reaches a request in the same cycle as its clear, the request stays set.
- R8: Op 4 sets and op 3 clears the selected enable latches, and `attn_out[i]` equals request i AND enable i.
- R9: Op 5 clears both requests and both enable latches.
- R10: `q_out` is 0 whenever `cmd_stb` is low or the operation is not a test (op 0 or 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sys_init | input | 1 | Initialize: clear requests and enables, cancel settle timers |
| cmd_stb | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 3 | Operation code |
| cmd_sel | input | 2 | Channel select |
| val_chg | input | 2 | Per-channel pulse: the channel's value was just changed |
| ext_req_in | input | 2 | Asynchronous external request pins |
| q_out | output | 1 | Test result for the current command |
| attn_out | output | 2 | Gated request per channel |
| busy_out | output | 2 | Output-in-transition flag per channel |

## Verification
The bench aims the settle timer's expiry at the cycle where a clear command lands. A design that let the clear win would drop a request that the host then never sees. It retriggers both the settle timer and the busy one-shot mid-window and checks the exact expiry edge, which catches a timer that ignores restarts or is off by one cycle. It also holds the external pin high across a clear, so a level-sensitive design would raise the request again at once. Finally it sends `sys_init` while a settle count is pending, which exposes a design that clears the request but lets the timer raise it again afterwards.

// File: rtl/dac_attn_pkg.sv
package dac_attn_pkg;
  localparam int N_CH = 2;

  typedef enum logic [2:0] {
    OP_TEST_GATED = 3'd0,
    OP_TEST_RAW   = 3'd1,
    OP_CLR_REQ    = 3'd2,
    OP_DISABLE    = 3'd3,
    OP_ENABLE     = 3'd4,
    OP_CLR_ALL    = 3'd5
  } attn_op_e;

  function automatic logic [N_CH-1:0] chan_mask(input logic [1:0] sel);
    case (sel)
      2'd0:    return 2'b01;
      2'd1:    return 2'b10;
      default: return 2'b11;
    endcase
  endfunction
endpackage

// File: rtl/attn_in_sync.sv
module attn_in_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  output logic rise
);
  logic s1, s2, prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= 1'b0;
      s2   <= 1'b0;
      prev <= 1'b0;
    end else begin
      s1   <= raw_in;
      s2   <= s1;
      prev <= s2;
    end
  end

  assign rise = s2 & ~prev;
endmodule

// File: rtl/attn_timer.sv
module attn_timer #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kill,
  input  logic load,
  output logic active,
  output logic expire
);
  localparam int W = $clog2(LEN + 1);
  localparam logic [W-1:0] LEN_W = W'(LEN);
  localparam logic [W-1:0] ONE_W = W'(1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (kill)      cnt <= '0;
    else if (load)      cnt <= LEN_W;
    else if (cnt != '0) cnt <= cnt - ONE_W;
  end

  assign active = (cnt != '0);
  assign expire = (cnt == ONE_W) && !load && !kill;

  always_comb assert_cnt_in_range_R3: assert (!rst_n || cnt <= LEN_W);

  assert_load_starts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !kill) |=> active);

  assert_expire_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !active);
endmodule

// File: rtl/attn_chan.sv
module attn_chan #(
  parameter int   SETTLE_CYC = 5000,
  parameter int   BUSY_CYC   = 3000,
  parameter logic EXT_SRC    = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sys_init,
  input  logic ext_raw,
  input  logic val_chg,
  input  logic clr_req,
  input  logic set_en,
  input  logic clr_en,
  output logic req,
  output logic en,
  output logic busy
);
  logic ext_rise, settle_done, settle_run, busy_done, set_evt;

  attn_in_sync u_sync (
    .clk(clk), .rst_n(rst_n), .raw_in(ext_raw), .rise(ext_rise)
  );

  attn_timer #(.LEN(SETTLE_CYC)) u_settle (
    .clk(clk), .rst_n(rst_n), .kill(sys_init), .load(val_chg),
    .active(settle_run), .expire(settle_done)
  );

  attn_timer #(.LEN(BUSY_CYC)) u_busy (
    .clk(clk), .rst_n(rst_n), .kill(1'b0), .load(val_chg),
    .active(busy), .expire(busy_done)
  );

  assign set_evt = (EXT_SRC & ext_rise) | settle_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        req <= 1'b0;
    else if (sys_init) req <= 1'b0;
    else if (set_evt)  req <= 1'b1;
    else if (clr_req)  req <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        en <= 1'b0;
    else if (sys_init) en <= 1'b0;
    else if (clr_en)   en <= 1'b0;
    else if (set_en)   en <= 1'b1;
  end

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt && !sys_init) |=> req);

  assert_clear_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !set_evt && !sys_init) |=> !req);

  assert_init_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sys_init |=> (!req && !en));
endmodule

// File: rtl/dac_attn_status.sv
module dac_attn_status
  import dac_attn_pkg::*;
#(
  parameter int             SETTLE_CYC = 5000,
  parameter int             BUSY_CYC   = 3000,
  parameter logic [N_CH-1:0] EXT_SRC_EN = 2'b11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sys_init,
  input  logic            cmd_stb,
  input  logic [2:0]      cmd_op,
  input  logic [1:0]      cmd_sel,
  input  logic [N_CH-1:0] val_chg,
  input  logic [N_CH-1:0] ext_req_in,
  output logic            q_out,
  output logic [N_CH-1:0] attn_out,
  output logic [N_CH-1:0] busy_out
);
  attn_op_e        op;
  logic [N_CH-1:0] mask, clr_req, set_en, clr_en, req, en;

  assign op   = attn_op_e'(cmd_op);
  assign mask = chan_mask(cmd_sel);

  always_comb begin
    clr_req = '0;
    set_en  = '0;
    clr_en  = '0;
    if (cmd_stb) begin
      case (op)
        OP_CLR_REQ: clr_req = mask;
        OP_DISABLE: clr_en  = mask;
        OP_ENABLE:  set_en  = mask;
        OP_CLR_ALL: begin
          clr_req = '1;
          clr_en  = '1;
        end
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    attn_chan #(
      .SETTLE_CYC(SETTLE_CYC), .BUSY_CYC(BUSY_CYC), .EXT_SRC(EXT_SRC_EN[i])
    ) u_ch (
      .clk(clk), .rst_n(rst_n), .sys_init(sys_init),
      .ext_raw(ext_req_in[i]), .val_chg(val_chg[i]),
      .clr_req(clr_req[i]), .set_en(set_en[i]), .clr_en(clr_en[i]),
      .req(req[i]), .en(en[i]), .busy(busy_out[i])
    );
  end

  assign attn_out = req & en;

  always_comb begin
    q_out = 1'b0;
    if (cmd_stb) begin
      case (op)
        OP_TEST_GATED: begin
          case (cmd_sel)
            2'd0:    q_out = attn_out[0];
            2'd1:    q_out = attn_out[1];
            default: q_out = |attn_out;
          endcase
        end
        OP_TEST_RAW: begin
          case (cmd_sel)
            2'd0:    q_out = req[0];
            2'd1:    q_out = req[1];
            2'd2:    q_out = !busy_out[0];
            default: q_out = !busy_out[1];
          endcase
        end
        default: q_out = 1'b0;
      endcase
    end
  end

  assert_clear_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && op == OP_CLR_ALL && !sys_init) |=> (en == '0));
endmodule

// File: tb/sim_dac_attn_status.sv
module sim_dac_attn_status;
  import dac_attn_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int S = 20;
  localparam int B = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sys_init = 1'b0;
  logic       cmd_stb = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [1:0] cmd_sel = 2'd0;
  logic [1:0] val_chg = 2'b00;
  logic [1:0] ext_req_in = 2'b00;
  logic       q_out;
  logic [1:0] attn_out, busy_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_attn_status #(.SETTLE_CYC(S), .BUSY_CYC(B)) u0 (
    .clk(clk), .rst_n(rst_n), .sys_init(sys_init), .cmd_stb(cmd_stb),
    .cmd_op(cmd_op), .cmd_sel(cmd_sel), .val_chg(val_chg),
    .ext_req_in(ext_req_in), .q_out(q_out), .attn_out(attn_out),
    .busy_out(busy_out)
  );

  task automatic chk(input logic [1:0] act, input logic [1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic test_q(input attn_op_e op, input logic [1:0] sel,
                        input logic exp, input string tag);
    @(negedge clk);
    cmd_stb = 1'b1; cmd_op = op; cmd_sel = sel;
    #(CLK_PERIOD/4);
    chk({1'b0, q_out}, {1'b0, exp}, tag);
    cmd_stb = 1'b0;
  endtask

  task automatic cmd(input attn_op_e op, input logic [1:0] sel);
    @(negedge clk);
    cmd_stb = 1'b1; cmd_op = op; cmd_sel = sel;
    @(negedge clk);
    cmd_stb = 1'b0;
  endtask

  task automatic pulse_chg(input int ch);
    @(negedge clk);
    val_chg[ch] = 1'b1;
    @(negedge clk);
    val_chg[ch] = 1'b0;
  endtask

  task automatic settle_all();
    ext_req_in = 2'b00;
    repeat (S + B + 6) @(negedge clk);
    cmd(OP_CLR_ALL, 2'd3);
  endtask

  task automatic t_reset();
    #1;
    chk(attn_out, 2'b00, "R1 attn after reset");
    chk(busy_out, 2'b00, "R1 busy after reset");
    test_q(OP_TEST_RAW, 2'd0, 1'b0, "R1 raw A after reset");
    test_q(OP_TEST_GATED, 2'd3, 1'b0, "R1 gated either after reset");
    test_q(OP_TEST_RAW, 2'd2, 1'b1, "R1 A settled after reset");
  endtask

  task automatic t_settle_delay();
    pulse_chg(0);
    repeat (S - 2) @(negedge clk);
    test_q(OP_TEST_RAW, 2'd0, 1'b0, "R3 A not yet set");
    test_q(OP_TEST_RAW, 2'd0, 1'b1, "R3 A set at settle count");
    test_q(OP_TEST_RAW, 2'd1, 1'b0, "R3 B untouched");
    settle_all();
  endtask

  task automatic t_settle_retrigger();
    pulse_chg(1);
    repeat (4) @(negedge clk);
    pulse_chg(1);
    repeat (S - 2) @(negedge clk);
    test_q(OP_TEST_RAW, 2'd1, 1'b0, "R3 B restart delays set");
    test_q(OP_TEST_RAW, 2'd1, 1'b1, "R3 B set after restart");
    settle_all();
  endtask

  task automatic t_busy();
    pulse_chg(0);
    #1 chk(busy_out, 2'b01, "R4 busy A rises");
    test_q(OP_TEST_RAW, 2'd2, 1'b0, "R4 A not settled");
    test_q(OP_TEST_RAW, 2'd3, 1'b1, "R4 B settled");
    repeat (B - 4) @(negedge clk);
    test_q(OP_TEST_RAW, 2'd2, 1'b0, "R4 A busy last cycle");
    test_q(OP_TEST_RAW, 2'd2, 1'b1, "R4 A settled after window");
    pulse_chg(0);
    repeat (3) @(negedge clk);
    pulse_chg(0);
    repeat (B - 1) @(negedge clk);
    #1 chk(busy_out, 2'b01, "R4 retrigger keeps busy");
    @(negedge clk);
    #1 chk(busy_out, 2'b00, "R4 busy ends after retrigger");
    settle_all();
  endtask

  task automatic t_ext();
    @(negedge clk);
    ext_req_in[1] = 1'b1;
    test_q(OP_TEST_RAW, 2'd1, 1'b0, "R2 B after edge 1");
    test_q(OP_TEST_RAW, 2'd1, 1'b0, "R2 B after edge 2");
    test_q(OP_TEST_RAW, 2'd1, 1'b1, "R2 B after edge 3");
    test_q(OP_TEST_RAW, 2'd0, 1'b0, "R2 A untouched");
    cmd(OP_CLR_REQ, 2'd1);
    repeat (4) @(negedge clk);
    test_q(OP_TEST_RAW, 2'd1, 1'b0, "R2 held pin no re-set");
    settle_all();
  endtask

  task automatic t_gate();
    @(negedge clk);
    ext_req_in = 2'b01;
    repeat (4) @(negedge clk);
    test_q(OP_TEST_GATED, 2'd0, 1'b0, "R5 gated A while disabled");
    test_q(OP_TEST_RAW, 2'd0, 1'b1, "R6 raw A ignores enable");
    #1 chk(attn_out, 2'b00, "R8 attn off while disabled");
    cmd(OP_ENABLE, 2'd0);
    #1 chk(attn_out, 2'b01, "R8 attn A after enable");
    test_q(OP_TEST_GATED, 2'd0, 1'b1, "R5 gated A");
    test_q(OP_TEST_GATED, 2'd1, 1'b0, "R5 gated B");
    test_q(OP_TEST_GATED, 2'd3, 1'b1, "R5 gated either");
    test_q(OP_TEST_GATED, 2'd2, 1'b1, "R5 gated either sel2");
    @(negedge clk);
    cmd_stb = 1'b0; cmd_op = OP_TEST_RAW; cmd_sel = 2'd0;
    #1 chk({1'b0, q_out}, 2'b00, "R10 no strobe gives q 0");
    test_q(OP_ENABLE, 2'd1, 1'b0, "R10 non-test op gives q 0");
    #1 chk(attn_out, 2'b01, "R8 enable B without request");
    cmd(OP_DISABLE, 2'd2);
    #1 chk(attn_out, 2'b00, "R8 disable both");
    test_q(OP_TEST_RAW, 2'd0, 1'b1, "R6 request kept after disable");
    cmd(OP_ENABLE, 2'd3);
    #1 chk(attn_out, 2'b01, "R8 enable both");
    cmd(OP_CLR_ALL, 2'd0);
    #1 chk(attn_out, 2'b00, "R9 clear-all attn");
    test_q(OP_TEST_RAW, 2'd0, 1'b0, "R9 clear-all request");
    @(negedge clk);
    ext_req_in = 2'b00;
    repeat (3) @(negedge clk);
    ext_req_in = 2'b01;
    repeat (4) @(negedge clk);
    #1 chk(attn_out, 2'b00, "R9 clear-all disabled enables");
    settle_all();
  endtask

  task automatic t_clear();
    @(negedge clk);
    ext_req_in = 2'b11;
    repeat (4) @(negedge clk);
    cmd(OP_CLR_REQ, 2'd0);
    test_q(OP_TEST_RAW, 2'd0, 1'b0, "R7 clear A only");
    test_q(OP_TEST_RAW, 2'd1, 1'b1, "R7 B kept");
    cmd(OP_CLR_REQ, 2'd2);
    test_q(OP_TEST_RAW, 2'd1, 1'b0, "R7 clear both");
    settle_all();
    pulse_chg(0);
    repeat (S - 1) @(negedge clk);
    cmd_stb = 1'b1; cmd_op = OP_CLR_REQ; cmd_sel = 2'd0;
    @(negedge clk);
    cmd_stb = 1'b0;
    test_q(OP_TEST_RAW, 2'd0, 1'b1, "R7 set wins over clear");
    settle_all();
  endtask

  task automatic t_init();
    cmd(OP_ENABLE, 2'd3);
    pulse_chg(0);
    @(negedge clk);
    sys_init = 1'b1;
    @(negedge clk);
    sys_init = 1'b0;
    #1 chk(attn_out, 2'b00, "R1 init clears");
    repeat (S + 3) @(negedge clk);
    test_q(OP_TEST_RAW, 2'd0, 1'b0, "R1 pending settle cancelled");
    @(negedge clk);
    ext_req_in = 2'b01;
    repeat (4) @(negedge clk);
    #1 chk(attn_out, 2'b00, "R1 init disabled enables");
    settle_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_settle_delay();
    t_settle_retrigger();
    t_busy();
    t_ext();
    t_gate();
    t_clear();
    t_init();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule